// File: doc/BRIEF.md
# Timed Idle Wakeup Controller

This block manages a light sleep state in which the processor is halted while a free-running divider keeps counting. Software raises a one-cycle sleep request. The controller then holds the processor halted until the chosen divider tap shows a falling edge. At that point it releases the halt and reports how execution continues. Execution either resumes in line at the instruction after the one that requested sleep, or vectors to the timer interrupt handler.

Three enables choose the release mode: the global interrupt enable, the timer interrupt enable and the timer enable. Only when all three are set does the release vector to the handler. The timer enable alone decides whether the timer interrupt latch is set at release. A watchdog interrupt that is pending when the request arrives takes precedence over the request. The sleep state is then not entered, and a one-cycle cancel pulse is issued.

The divider is a counter that is cleared by reset and advances by one on every clock. Because the tap runs independently of the request, the halted time can be shorter than one full tap period.

Top module: `idle_wake_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, cpu_halt, wake_valid, sleep_cancel and tmr_irq_latch are all 0.
- R2: If sleep_req is 1 while the block is awake and wdt_pend is 0, cpu_halt reads 1 from the next cycle on.
- R3: If sleep_req is 1 while the block is awake and wdt_pend is 1, cpu_halt stays 0 and sleep_cancel is 1 for exactly the next cycle.
- R4: The divider counter is 0 after reset and increments every clock. tap_sel value s selects counter bit s+1. The halt ends at the clock edge that closes the first halted cycle in which the selected bit is 0 and was 1 in the cycle before.
- R5: A selected tap that is already low at entry does not cause a release. It must rise and fall again, which can take a full period of 2^(s+2) cycles.
- R6: wake_valid is 1 for exactly one cycle, namely the first cycle after cpu_halt falls.
- R7: wake_cause reads 1 (vector to the timer interrupt) together with wake_valid only if gie, tmr_ie and tmr_en were all 1 in the release cycle. Otherwise it reads 0 (resume in line).
- R8: tmr_irq_latch becomes 1 at release when tmr_en is 1, and stays 1 until tmr_irq_ack is 1. An ack with no release clears it at the next edge.
- R9: When a release with tmr_en=1 and tmr_irq_ack fall in the same cycle, tmr_irq_latch becomes 1.
- R10: sleep_req while halted is ignored: no cancel pulse even with wdt_pend=1, and the release cycle is unchanged.
- R11: When entry falls just before a tap edge, the release follows after one halted cycle, which is shorter than a tap period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter the sleep state |
| tap_sel | input | 2 | Divider tap select (bit tap_sel+1) |
| tmr_en | input | 1 | Timer enable |
| gie | input | 1 | Global interrupt enable |
| tmr_ie | input | 1 | Individual timer interrupt enable |
| wdt_pend | input | 1 | Watchdog interrupt pending |
| tmr_irq_ack | input | 1 | Clears the timer interrupt latch |
| cpu_halt | output | 1 | Processor halt |
| wake_valid | output | 1 | One-cycle release strobe |
| wake_cause | output | 1 | 1 = vector to timer interrupt, 0 = resume in line |
| sleep_cancel | output | 1 | One-cycle pulse when watchdog cancels entry |
| tmr_irq_latch | output | 1 | Timer interrupt latch |

## Verification
The timer latch can see a release set it and an acknowledge clear it in the same cycle. To provoke this, the bench holds tmr_irq_ack high for the whole halted interval of a release with tmr_en set. The bench expects the latch to read 1 in the wake cycle, and 0 one cycle after the ack that remains high. A second collision is a sleep request with a watchdog pending while already halted; here the bench expects no cancel and an unchanged release cycle.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } idle_state_e;

    typedef enum logic {
        WAKE_INLINE = 1'b0,
        WAKE_VECTOR = 1'b1
    } wake_cause_e;

    typedef struct packed {
        logic gie;
        logic tmr_ie;
        logic tmr_en;
    } irq_cfg_t;

    typedef struct packed {
        wake_cause_e cause;
        logic        set_latch;
    } release_plan_t;

    function automatic int unsigned tap_bit_pos(input int unsigned idx,
                                                input int unsigned lsb,
                                                input int unsigned step);
        return lsb + idx * step;
    endfunction

endpackage

// File: rtl/iwc_tap_divider.sv
module iwc_tap_divider #(
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned TAP_LSB  = 1,
    parameter int unsigned TAP_STEP = 1,
    localparam int unsigned SEL_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_fall
);
    import idle_wake_pkg::*;

    logic [DIV_W-1:0]    div_cnt;
    logic [NUM_TAPS-1:0] tap_vec;
    logic                tap_now;
    logic                tap_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            tap_prev <= 1'b0;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
            tap_prev <= tap_now;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned POS = tap_bit_pos(g, TAP_LSB, TAP_STEP);
        assign tap_vec[g] = div_cnt[POS];
    end

    assign tap_now  = tap_vec[tap_sel];
    assign tap_fall = tap_prev & ~tap_now;

endmodule

// File: rtl/iwc_mode_decode.sv
module iwc_mode_decode (
    input  idle_wake_pkg::irq_cfg_t      cfg,
    output idle_wake_pkg::release_plan_t plan
);
    import idle_wake_pkg::*;

    always_comb begin
        plan.set_latch = cfg.tmr_en;
        plan.cause     = (cfg.gie && cfg.tmr_ie && cfg.tmr_en) ? WAKE_VECTOR : WAKE_INLINE;
    end

endmodule

// File: rtl/iwc_sleep_fsm.sv
module iwc_sleep_fsm (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sleep_req,
    input  logic                         wdt_pend,
    input  logic                         tap_fall,
    input  logic                         irq_ack,
    input  idle_wake_pkg::release_plan_t plan,
    output logic                         halt,
    output logic                         wake_valid,
    output idle_wake_pkg::wake_cause_e   wake_cause,
    output logic                         cancel,
    output logic                         irq_latch
);
    import idle_wake_pkg::*;

    idle_state_e state;
    logic        do_release;
    logic        do_enter;
    logic        do_cancel;

    always_comb begin
        do_release = (state == ST_HALT) && tap_fall;
        do_enter   = (state == ST_RUN) && sleep_req && !wdt_pend;
        do_cancel  = (state == ST_RUN) && sleep_req && wdt_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            wake_valid <= 1'b0;
            wake_cause <= WAKE_INLINE;
            cancel     <= 1'b0;
        end else begin
            wake_valid <= do_release;
            cancel     <= do_cancel;
            if (do_release) begin
                state      <= ST_RUN;
                wake_cause <= plan.cause;
            end else if (do_enter) begin
                state <= ST_HALT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_latch <= 1'b0;
        end else if (do_release && plan.set_latch) begin
            irq_latch <= 1'b1;
        end else if (irq_ack) begin
            irq_latch <= 1'b0;
        end
    end

    assign halt = (state == ST_HALT);

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned TAP_LSB  = 1,
    parameter int unsigned TAP_STEP = 1,
    localparam int unsigned SEL_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             tmr_en,
    input  logic             gie,
    input  logic             tmr_ie,
    input  logic             wdt_pend,
    input  logic             tmr_irq_ack,
    output logic             cpu_halt,
    output logic             wake_valid,
    output logic             wake_cause,
    output logic             sleep_cancel,
    output logic             tmr_irq_latch
);
    import idle_wake_pkg::*;

    logic          tap_fall;
    irq_cfg_t      cfg;
    release_plan_t plan;
    wake_cause_e   cause_q;

    assign cfg = '{gie: gie, tmr_ie: tmr_ie, tmr_en: tmr_en};

    iwc_tap_divider #(
        .DIV_W   (DIV_W),
        .NUM_TAPS(NUM_TAPS),
        .TAP_LSB (TAP_LSB),
        .TAP_STEP(TAP_STEP)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .tap_sel (tap_sel),
        .tap_fall(tap_fall)
    );

    iwc_mode_decode u_mode (
        .cfg (cfg),
        .plan(plan)
    );

    iwc_sleep_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .wdt_pend  (wdt_pend),
        .tap_fall  (tap_fall),
        .irq_ack   (tmr_irq_ack),
        .plan      (plan),
        .halt      (cpu_halt),
        .wake_valid(wake_valid),
        .wake_cause(cause_q),
        .cancel    (sleep_cancel),
        .irq_latch (tmr_irq_latch)
    );

    assign wake_cause = cause_q;

endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk (
    input logic clk,
    input logic rst,
    input logic sleep_req,
    input logic wdt_pend,
    input logic gie,
    input logic tmr_ie,
    input logic tmr_en,
    input logic tmr_irq_ack,
    input logic cpu_halt,
    input logic wake_valid,
    input logic wake_cause,
    input logic sleep_cancel,
    input logic tmr_irq_latch,
    input logic tap_fall
);

    p_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && sleep_req && !wdt_pend) |=> cpu_halt);

    p_cancel_no_halt_r3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && sleep_req && wdt_pend) |=> (sleep_cancel && !cpu_halt));

    p_release_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && !tap_fall) |=> cpu_halt);

    p_wake_follows_fall_r6: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> $fell(cpu_halt));

    p_wake_single_r6: assert property (@(posedge clk) disable iff (rst)
        wake_valid |=> !wake_valid);

    p_vector_all_enables_r7: assert property (@(posedge clk) disable iff (rst)
        (wake_valid && wake_cause) |-> $past(gie && tmr_ie && tmr_en));

    p_latch_on_release_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && tap_fall && tmr_en) |=> tmr_irq_latch);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tmr_irq_latch && !tmr_irq_ack) |=> tmr_irq_latch);

    p_halted_req_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && sleep_req) |=> !sleep_cancel);

endmodule

bind idle_wake_ctrl idle_wake_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_req    (sleep_req),
    .wdt_pend     (wdt_pend),
    .gie          (gie),
    .tmr_ie       (tmr_ie),
    .tmr_en       (tmr_en),
    .tmr_irq_ack  (tmr_irq_ack),
    .cpu_halt     (cpu_halt),
    .wake_valid   (wake_valid),
    .wake_cause   (wake_cause),
    .sleep_cancel (sleep_cancel),
    .tmr_irq_latch(tmr_irq_latch),
    .tap_fall     (tap_fall)
);

// File: tb/test_idle_wake_ctrl.sv
`timescale 1ns/1ps
module test_idle_wake_ctrl;

    typedef struct {
        logic [7:0] at_cnt;
        logic       vec;
        logic       latch;
    } wake_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [1:0] tap_sel = 2'd0;
    logic       tmr_en = 1'b0;
    logic       gie = 1'b0;
    logic       tmr_ie = 1'b0;
    logic       wdt_pend = 1'b0;
    logic       tmr_irq_ack = 1'b0;
    logic       cpu_halt;
    logic       wake_valid;
    logic       wake_cause;
    logic       sleep_cancel;
    logic       tmr_irq_latch;

    int checks = 0;
    int errors = 0;
    int wakes  = 0;
    logic       exp_halt = 1'b0;
    logic [7:0] cnt_m = 8'd0;
    wake_item_t exp_q[$];

    always #2 clk = ~clk;

    idle_wake_ctrl i_idle_wake_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .tap_sel      (tap_sel),
        .tmr_en       (tmr_en),
        .gie          (gie),
        .tmr_ie       (tmr_ie),
        .wdt_pend     (wdt_pend),
        .tmr_irq_ack  (tmr_irq_ack),
        .cpu_halt     (cpu_halt),
        .wake_valid   (wake_valid),
        .wake_cause   (wake_cause),
        .sleep_cancel (sleep_cancel),
        .tmr_irq_latch(tmr_irq_latch)
    );

    // Divider reference (R4): cleared by reset, +1 per clock.
    always @(posedge clk) cnt_m <= rst ? 8'd0 : cnt_m + 8'd1;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Monitor: halt window and scoreboard of wake events.
    always @(negedge clk) begin
        if (!rst) begin
            if (wake_valid) begin
                exp_halt = 1'b0;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6: actual unexpected wake expected none");
                end else begin
                    wake_item_t it;
                    it = exp_q.pop_front();
                    checks++;
                    if (cnt_m !== it.at_cnt) begin
                        errors++;
                        $display("FAIL R4/R5/R11 release time: actual cnt %0d expected %0d", cnt_m, it.at_cnt);
                    end
                    check("R7 wake_cause", wake_cause, it.vec);
                    check("R8/R9 latch at wake", tmr_irq_latch, it.latch);
                end
                wakes++;
            end
            check("R2/R6 cpu_halt", cpu_halt, exp_halt);
        end
    end

    task automatic wait_mod(input int m, input int r);
        while ((int'(cnt_m) % m) != r) @(negedge clk);
    endtask

    // Driver: issue a sleep request and push the expected wake item.
    task automatic sleep_expect(input logic vec, input logic latch);
        int period;
        int c;
        wake_item_t it;
        period = 1 << (int'(tap_sel) + 2);
        c = (int'(cnt_m) + 1) % 256;
        while ((c % period) != 0) c = (c + 1) % 256;
        it.at_cnt = 8'((c + 1) % 256);
        it.vec    = vec;
        it.latch  = latch;
        exp_q.push_back(it);
        sleep_req = 1'b1;
        @(posedge clk);
        #1 exp_halt = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic wait_wake();
        int target;
        target = wakes + 1;
        while (wakes < target) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 halt in reset", cpu_halt, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cpu_halt", cpu_halt, 1'b0);
        check("R1 wake_valid", wake_valid, 1'b0);
        check("R1 sleep_cancel", sleep_cancel, 1'b0);
        check("R1 tmr_irq_latch", tmr_irq_latch, 1'b0);

        // R4/R7: tap 0, no enables -> in-line resume, no latch.
        tap_sel = 2'd0;
        wait_mod(4, 1);
        sleep_expect(1'b0, 1'b0);
        wait_wake();

        // R5/R8: tap low at entry waits a full period; latch set.
        tap_sel = 2'd1; tmr_en = 1'b1;
        wait_mod(8, 0);
        sleep_expect(1'b0, 1'b1);
        wait_wake();
        check("R8 latch held", tmr_irq_latch, 1'b1);
        tmr_irq_ack = 1'b1;
        @(negedge clk);
        tmr_irq_ack = 1'b0;
        check("R8 ack clears", tmr_irq_latch, 1'b0);

        // R11: entry just before the edge; gie/ie set but timer off -> in line.
        tmr_en = 1'b0; gie = 1'b1; tmr_ie = 1'b1;
        wait_mod(8, 7);
        sleep_expect(1'b0, 1'b0);
        wait_wake();

        // R7: all enables -> vector.
        tap_sel = 2'd2; tmr_en = 1'b1;
        wait_mod(16, 3);
        sleep_expect(1'b1, 1'b1);
        wait_wake();
        tmr_irq_ack = 1'b1;
        @(negedge clk);
        tmr_irq_ack = 1'b0;
        check("R8 ack clears after vector", tmr_irq_latch, 1'b0);

        // R3: watchdog pending cancels entry.
        wdt_pend = 1'b1; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; wdt_pend = 1'b0;
        check("R3 cancel pulse", sleep_cancel, 1'b1);
        @(negedge clk);
        check("R3 cancel ends", sleep_cancel, 1'b0);
        check("R3 no wake", wake_valid, 1'b0);

        // R10: requests while halted are ignored.
        tap_sel = 2'd3; tmr_ie = 1'b0;
        wait_mod(32, 2);
        sleep_expect(1'b0, 1'b1);
        wdt_pend = 1'b1; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; wdt_pend = 1'b0;
        check("R10 no cancel while halted", sleep_cancel, 1'b0);
        wait_wake();
        tmr_irq_ack = 1'b1;
        @(negedge clk);
        tmr_irq_ack = 1'b0;
        check("R8 latch cleared", tmr_irq_latch, 1'b0);

        // R9: ack high across release -> set wins in wake cycle.
        tap_sel = 2'd2; tmr_ie = 1'b1;
        wait_mod(16, 5);
        tmr_irq_ack = 1'b1;
        sleep_expect(1'b1, 1'b1);
        wait_wake();
        check("R9 later ack clears", tmr_irq_latch, 1'b0);
        tmr_irq_ack = 1'b0;

        check("R6 no pending wakes", 1'(exp_q.size() != 0), 1'b0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule